// File: doc/BRIEF.md
# Mode-Selectable Shift-Count Left Shifter

This block performs a logical left shift of a 64-bit operand and registers the result. The operation can be 32 bits or 64 bits wide. The shift amount comes from a full 64-bit count value. A two-bit mode picks how that count is read:

- **Wrapping:** only the low bits that index the operand width are used.
- **Low-byte:** only the low eight bits are used, and a result of zero is forced once that byte reaches the width.
- **Unmasked:** the whole unsigned count is used, and any count at or beyond the width gives zero.

The block exists so that one datapath can reproduce each of these shift-count conventions.

Two paths run side by side:

- a barrel shifter of log2(width) mux stages, driven by the low count bits;
- a comparator that finds out-of-range counts.

A final select then zeroes the result when the count is out of range. Every shift therefore takes exactly one clock cycle from `valid_in` to `valid_out`, whatever the count.

Top module: `shl_count_unit`

## Requirements
- R1: `valid_out` equals `valid_in` delayed by exactly one clock cycle. Every accepted shift shows its result on `result` in that next cycle, whatever the count value.
- R2: While `rst` is high at a clock edge (synchronous, active high), `result` becomes zero and `valid_out` becomes 0.
- R3: With `mode`=2'b00 and `wide`=0 (32-bit), the shift amount is `count` modulo 32. A count of 32 therefore shifts by 0.
- R4: With `mode`=2'b00 and `wide`=1 (64-bit), the shift amount is `count` modulo 64. Bits above bit 5 are ignored.
- R5: With `mode`=2'b01, the amount is `count[7:0]`. If that byte is at least the width (32 or 64), the result is zero. A count of 256 acts as a shift by 0.
- R6: With `mode`=2'b10, the count is not masked. Any count at or above the width, including counts with only high bits set, gives zero. Smaller counts shift normally.
- R7: With `wide`=0, `operand[63:32]` has no effect, `result[63:32]` is zero, and bits shifted past bit 31 are discarded.
- R8: `mode`=2'b11 behaves exactly as `mode`=2'b10.
- R9: In a cycle with `valid_in` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operand, count and controls are valid this cycle |
| operand | input | 64 | Value to shift |
| count | input | 64 | Raw shift-count value |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| mode | input | 2 | Count reading: 00 wrapping, 01 low-byte, 10/11 unmasked |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |
| result | output | 64 | Registered shifted value |

## Verification
The hardest case to reach is a count whose low bits select a legal shift while its upper bits should force zero. Two examples:

- a count of 2^40 + 3 in unmasked mode;
- a count of 288 in low-byte mode, whose low byte is 32, at 32-bit width.

A sweep of small counts never produces these. The bench therefore drives a single set bit through every count from 0 to 300 in all four modes and both widths, which crosses the width, byte and 256 wrap boundaries. It then adds directed counts that set only high bits, or mix high bits with small low bits.

A further test sets the upper operand half in 32-bit mode. The bench compares every result with a behavioural model written from the requirements.

// File: rtl/shl_count_unit.sv
module shl_count_unit #(
  parameter int XLEN = 64,
  parameter int CNTW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_in,
  input  logic [XLEN-1:0] operand,
  input  logic [CNTW-1:0] count,
  input  logic            wide,
  input  logic [1:0]      mode,
  output logic            valid_out,
  output logic [XLEN-1:0] result
);
  localparam int SW   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;
  localparam int HSW  = SW - 1;

  logic [SW-1:0]   amt;
  logic            big_byte, big_full, kill;
  logic [XLEN-1:0] src, shifted, trimmed, nxt;
  logic [XLEN-1:0] stage [SW+1];

  assign amt = wide ? count[SW-1:0] : {1'b0, count[HSW-1:0]};

  assign big_byte = wide ? |count[7:SW] : |count[7:HSW];
  assign big_full = wide ? |count[CNTW-1:SW] : |count[CNTW-1:HSW];

  always_comb begin
    case (mode)
      2'b00:   kill = 1'b0;
      2'b01:   kill = big_byte;
      default: kill = big_full;
    endcase
  end

  assign src      = wide ? operand : {{HALF{1'b0}}, operand[HALF-1:0]};
  assign stage[0] = src;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
  end

  assign shifted = stage[SW];
  assign trimmed = wide ? shifted : {{HALF{1'b0}}, shifted[HALF-1:0]};
  assign nxt     = kill ? '0 : trimmed;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= nxt;
    end
  end
endmodule

module shl_count_unit_chk #(
  parameter int XLEN = 64,
  parameter int CNTW = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_in,
  input logic [XLEN-1:0] operand,
  input logic [CNTW-1:0] count,
  input logic            wide,
  input logic [1:0]      mode,
  input logic            valid_out,
  input logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  assert_wrap32_zero_R3: assert property (@(posedge clk) disable iff (rst)
    valid_in && mode == 2'b00 && !wide && count[4:0] == 5'd0
    |=> result == {{HALF{1'b0}}, $past(operand[HALF-1:0])});
  assert_wrap64_zero_R4: assert property (@(posedge clk) disable iff (rst)
    valid_in && mode == 2'b00 && wide && count[5:0] == 6'd0
    |=> result == $past(operand));
  assert_byte_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    valid_in && mode == 2'b01 && wide && count[7:0] == 8'd0
    |=> result == $past(operand));
  assert_full_big_R6: assert property (@(posedge clk) disable iff (rst)
    valid_in && mode == 2'b10 && wide && |count[CNTW-1:6] |=> result == '0);
  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
    valid_in && !wide |=> result[XLEN-1:HALF] == '0);
  assert_mode3_big_R8: assert property (@(posedge clk) disable iff (rst)
    valid_in && mode == 2'b11 && |count[CNTW-1:5] && !wide |=> result == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result));
endmodule

bind shl_count_unit shl_count_unit_chk #(.XLEN(XLEN), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .operand(operand), .count(count),
  .wide(wide), .mode(mode), .valid_out(valid_out), .result(result)
);

// File: tb/test_shl_count_unit.sv
module test_shl_count_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        valid_in = 0;
  logic [63:0] operand = '0;
  logic [63:0] count = '0;
  logic        wide = 0;
  logic [1:0]  mode = 2'b00;
  logic        valid_out;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  shl_count_unit i_shl_count_unit (
    .clk(clk), .rst(rst), .valid_in(valid_in), .operand(operand), .count(count),
    .wide(wide), .mode(mode), .valid_out(valid_out), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] op, input logic [63:0] cnt,
                                        input logic w, input logic [1:0] m);
    longint unsigned width = w ? 64 : 32;
    longint unsigned e;
    logic z;
    logic [63:0] r;
    if (m == 2'b00) begin
      e = cnt % width; z = 0;
    end else if (m == 2'b01) begin
      e = cnt % 256; z = (e >= width);
    end else begin
      e = cnt; z = (cnt >= width);
    end
    if (z) return 64'd0;
    if (w) r = op << e;
    else   r = ({32'd0, op[31:0]} << e) & 64'h0000_0000_FFFF_FFFF;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] op, input logic [63:0] cnt,
                       input logic w, input logic [1:0] m);
    @(negedge clk);
    valid_in = 1; operand = op; count = cnt; wide = w; mode = m;
    @(posedge clk); #1;
    valid_in = 0;
  endtask

  function automatic string tag(input logic w, input logic [1:0] m);
    if (m == 2'b00) return w ? "R4" : "R3";
    if (m == 2'b01) return "R5";
    if (m == 2'b10) return "R6";
    return "R8";
  endfunction

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R2 result", result, 64'd0);
    check("R2 valid_out", {63'd0, valid_out}, 64'd0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_sweep;
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c <= 300; c++) begin
          issue(64'd1, 64'(c), w[0], m[1:0]);
          check(tag(w[0], m[1:0]), result, model(64'd1, 64'(c), w[0], m[1:0]));
          check("R1 valid_out", {63'd0, valid_out}, 64'd1);
        end
  endtask

  task automatic t_high_counts;
    logic [63:0] cs [6] = '{64'h100_0000_0003, 64'h8000_0000_0000_0000, 64'd288,
                            64'd320, 64'd259, 64'h1_0000_0040};
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 6; k++) begin
          issue(64'hA5A5_5A5A_C3C3_3C3C, cs[k], w[0], m[1:0]);
          check(tag(w[0], m[1:0]), result,
                model(64'hA5A5_5A5A_C3C3_3C3C, cs[k], w[0], m[1:0]));
        end
  endtask

  task automatic t_narrow_upper;
    issue(64'hFFFF_FFFF_0000_0001, 64'd4, 1'b0, 2'b00);
    check("R7 upper ignored", result, 64'h10);
    issue(64'hFFFF_FFFF_8000_0001, 64'd1, 1'b0, 2'b10);
    check("R7 bits discarded", result, 64'h2);
    issue(64'hFFFF_FFFF_0000_0001, 64'd0, 1'b1, 2'b00);
    check("R4 wide uses upper", result, 64'hFFFF_FFFF_0000_0001);
  endtask

  task automatic t_hold;
    issue(64'h1234, 64'd8, 1'b1, 2'b10);
    check("R9 setup", result, 64'h12_3400);
    @(negedge clk);
    operand = 64'hFFFF; count = 64'd1; mode = 2'b00;
    @(posedge clk); #1;
    check("R9 hold", result, 64'h12_3400);
    check("R1 valid low", {63'd0, valid_out}, 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset;
    t_sweep;
    t_high_counts;
    t_narrow_upper;
    t_hold;
    t_reset;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule